// File: doc/BRIEF.md
# Chainable Two-Timer Counter Pair

This block holds two identical up-counting timers, A and B, that can steer each other inside the block. Each timer has a prescaler, an auto-reload limit and one compare value. A master-mode selector picks what drives its trigger output. A slave-mode controller takes the other timer's trigger output as internal trigger 0.

Depending on its slave mode, a timer can have its counter cleared by the other timer, gated by it, started by it, or clocked by it. The usual chained use makes timer A a programmable prescaler for timer B. A drives a pulse on its trigger output at every update event, and B counts those pulses in place of its own clock.

Configuration is a whole-register write. A single shared field bus carries the settings, and a 2-bit write strobe chooses the timer (bit 0 for A, bit 1 for B). Every field of the chosen timer is loaded at that clock edge.

Top module: `tmr_pair`

## Requirements
- R1: After reset both counters read 0, both trigger outputs are 0 and both compare outputs are 0. The reset values are compare 0, prescaler 0, auto-reload all ones and all modes 000.
- R2: With slave mode 000 and the enable bit set, a counter advances once every (prescaler + 1) clocks. When it advances from the auto-reload value it wraps to 0, and that wrap is an update event.
- R3: Master mode 010 puts a one-clock pulse on the trigger output after each update event. With timer B in slave mode 111 and trigger select 000, B advances exactly once per overflow of A, provided A's update period is at least 2 clocks.
- R4: Writing with the update-request bit set clears the counter and the prescaler and raises an update event. Under master mode 000 the trigger output pulses once for each such write.
- R5: Master mode 001 makes the trigger output follow the timer's enable bit one clock later. Master mode 011 holds the trigger output at 0.
- R6: Any master mode with its top bit set (1xx) drives the trigger output from the compare output, one clock later. Each rising edge of that output is one event for the other timer.
- R7: The compare output is 1 exactly while the counter is below the compare value. It is never 1 for a compare value of 0, and it is always 1 for a compare value above the auto-reload value.
- R8: In slave mode 101 (gated) the counter advances only while the selected trigger is high.
- R9: In slave mode 110 (trigger) a rising edge of the selected trigger sets the timer's enable bit.
- R10: In slave mode 100 (reset) a rising edge of the selected trigger clears the counter and the prescaler.
- R11: A trigger-select value other than 000 selects a trigger that is held at 0, so the other timer has no effect.
- R12: While the enable bit is 0 the counter holds its value, in every slave mode, including slave mode 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 2 | Write strobe per timer (bit 0 = A, bit 1 = B) |
| wr_cen | input | 1 | Enable bit to load |
| wr_ug | input | 1 | Update request (action only, not stored) |
| wr_mms | input | 3 | Master mode to load |
| wr_ts | input | 3 | Trigger select to load |
| wr_sms | input | 3 | Slave mode to load |
| wr_psc | input | 16 | Prescaler to load |
| wr_arr | input | 16 | Auto-reload value to load |
| wr_ccr | input | 16 | Compare value to load |
| cnt_a | output | 16 | Counter of timer A |
| cnt_b | output | 16 | Counter of timer B |
| oc | output | 2 | Compare outputs (bit 0 = A, bit 1 = B) |
| trgo | output | 2 | Trigger outputs (bit 0 = A, bit 1 = B) |

## Verification
The counter properties hold only in cycles with no configuration write on that timer, so a write may override any counting rule. The bench therefore treats the cycle of each write as exempt, and reads results only once the writes have settled.

The chained counting rule assumes the master's update period is at least two clocks, so that its trigger output falls between pulses. Every table vector and directed test keeps A's period at two clocks or more. Before A is reconfigured, it is silenced with master mode 011, so that no stray trigger edge reaches B.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W = 16;

    typedef enum logic [2:0] {
        MM_UG  = 3'b000,
        MM_EN  = 3'b001,
        MM_UPD = 3'b010,
        MM_LOW = 3'b011,
        MM_OC  = 3'b100
    } mms_e;

    typedef enum logic [2:0] {
        SM_OFF  = 3'b000,
        SM_RST  = 3'b100,
        SM_GATE = 3'b101,
        SM_TRIG = 3'b110,
        SM_ECM  = 3'b111
    } sms_e;

    typedef struct packed {
        logic       cen;
        logic [2:0] mms;
        logic [2:0] ts;
        logic [2:0] sms;
    } mode_t;

    function automatic logic pick_trig(input logic [2:0] ts, input logic itr0);
        return (ts == 3'b000) ? itr0 : 1'b0;
    endfunction

    function automatic logic pick_trgo(input logic [2:0] mms, input logic ug,
                                       input logic cen, input logic upd,
                                       input logic cmp);
        logic r;
        if (mms[2]) r = cmp;
        else begin
            case (mms)
                MM_UG:   r = ug;
                MM_EN:   r = cen;
                MM_UPD:  r = upd;
                default: r = 1'b0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= d;
    end

    assign rise = d & ~q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic         wr_cen,
    input  logic         wr_ug,
    input  logic [2:0]   wr_mms,
    input  logic [2:0]   wr_ts,
    input  logic [2:0]   wr_sms,
    input  logic [W-1:0] wr_psc,
    input  logic [W-1:0] wr_arr,
    input  logic [W-1:0] wr_ccr,
    input  logic         itr0,
    output logic [W-1:0] cnt,
    output logic         oc,
    output logic         trgo
);
    mode_t        md;
    logic [W-1:0] psc, arr, ccr, pcnt;
    logic         trig, rise, run, tick, ug_evt, clr_evt, ovf, trgo_d;

    assign trig = pick_trig(md.ts, itr0);

    tmr_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .d    (trig),
        .rise (rise)
    );

    always_comb begin
        ug_evt  = wr && wr_ug;
        clr_evt = (md.sms == SM_RST) && rise;
        run     = md.cen && !((md.sms == SM_GATE) && !trig);
        tick    = (md.sms == SM_ECM) ? rise : (pcnt == psc);
        ovf     = run && tick && (cnt == arr) && !ug_evt && !clr_evt;
        oc      = cnt < ccr;
        trgo_d  = pick_trgo(md.mms, ug_evt, md.cen, ovf || ug_evt, oc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            md   <= '0;
            psc  <= '0;
            arr  <= '1;
            ccr  <= '0;
            cnt  <= '0;
            pcnt <= '0;
            trgo <= 1'b0;
        end else begin
            trgo <= trgo_d;
            if (wr) begin
                md  <= '{cen: wr_cen, mms: wr_mms, ts: wr_ts, sms: wr_sms};
                psc <= wr_psc;
                arr <= wr_arr;
                ccr <= wr_ccr;
            end else if ((md.sms == SM_TRIG) && rise) begin
                md.cen <= 1'b1;
            end

            if (ug_evt || clr_evt) begin
                cnt  <= '0;
                pcnt <= '0;
            end else if (run) begin
                if (md.sms == SM_ECM) begin
                    if (rise) cnt <= (cnt == arr) ? '0 : cnt + 1'b1;
                end else if (pcnt == psc) begin
                    pcnt <= '0;
                    cnt  <= (cnt == arr) ? '0 : cnt + 1'b1;
                end else begin
                    pcnt <= pcnt + 1'b1;
                end
            end
        end
    end

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt == '0));

    // R8
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((md.sms == SM_GATE) && !trig && !wr) |=> ($stable(cnt) && $stable(pcnt)));

    // R10
    slave_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ((md.sms == SM_RST) && rise && !wr) |=> (cnt == '0));

    // R3
    ecm_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        ((md.sms == SM_ECM) && !rise && !wr) |=> $stable(cnt));

    // R12
    disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!md.cen && !wr && !clr_evt) |=> $stable(cnt));

    // R9
    trig_start_chk: assert property (@(posedge clk) disable iff (rst)
        ((md.sms == SM_TRIG) && rise && !wr) |=> md.cen);
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   wr_en,
    input  logic         wr_cen,
    input  logic         wr_ug,
    input  logic [2:0]   wr_mms,
    input  logic [2:0]   wr_ts,
    input  logic [2:0]   wr_sms,
    input  logic [W-1:0] wr_psc,
    input  logic [W-1:0] wr_arr,
    input  logic [W-1:0] wr_ccr,
    output logic [W-1:0] cnt_a,
    output logic [W-1:0] cnt_b,
    output logic [1:0]   oc,
    output logic [1:0]   trgo
);
    localparam int NT = 2;

    logic [NT-1:0]        trgo_w, oc_w;
    logic [NT-1:0][W-1:0] cnt_w;

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        tmr_unit #(.W(W)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .wr     (wr_en[i]),
            .wr_cen (wr_cen),
            .wr_ug  (wr_ug),
            .wr_mms (wr_mms),
            .wr_ts  (wr_ts),
            .wr_sms (wr_sms),
            .wr_psc (wr_psc),
            .wr_arr (wr_arr),
            .wr_ccr (wr_ccr),
            .itr0   (trgo_w[NT-1-i]),
            .cnt    (cnt_w[i]),
            .oc     (oc_w[i]),
            .trgo   (trgo_w[i])
        );
    end

    assign cnt_a = cnt_w[0];
    assign cnt_b = cnt_w[1];
    assign oc    = oc_w;
    assign trgo  = trgo_w;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (trgo == 2'b00 && cnt_a == '0 && cnt_b == '0));
endmodule

// File: tb/tb_tmr_pair.sv
module tb_tmr_pair;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   wr_en = '0;
    logic         wr_cen = 1'b0, wr_ug = 1'b0;
    logic [2:0]   wr_mms = '0, wr_ts = '0, wr_sms = '0;
    logic [W-1:0] wr_psc = '0, wr_arr = '0, wr_ccr = '0;
    logic [W-1:0] cnt_a, cnt_b;
    logic [1:0]   oc, trgo;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    tmr_pair #(.W(W)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cen(wr_cen), .wr_ug(wr_ug),
        .wr_mms(wr_mms), .wr_ts(wr_ts), .wr_sms(wr_sms), .wr_psc(wr_psc),
        .wr_arr(wr_arr), .wr_ccr(wr_ccr), .cnt_a(cnt_a), .cnt_b(cnt_b),
        .oc(oc), .trgo(trgo)
    );

    // psc, arr, cycles of run for timer A
    localparam int NV = 6;
    localparam int VEC [NV][3] = '{
        '{0, 4, 23}, '{0, 1, 10}, '{2, 3, 50},
        '{1, 0, 9},  '{3, 2, 40}, '{0, 9, 100}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a negedge; returns at the negedge after the write edge
    task automatic wr(input int sel, input bit cen, input bit ug,
                      input logic [2:0] mms, input logic [2:0] ts, input logic [2:0] sms,
                      input int psc, input int arr, input int ccr);
        wr_en  = (sel == 0) ? 2'b01 : 2'b10;
        wr_cen = cen; wr_ug = ug; wr_mms = mms; wr_ts = ts; wr_sms = sms;
        wr_psc = W'(psc); wr_arr = W'(arr); wr_ccr = W'(ccr);
        @(posedge clk);
        @(negedge clk);
        wr_en = 2'b00; wr_ug = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // silence A: trigger output held low, counter cleared
    task automatic quiet_a();
        wr(0, 0, 0, 3'b011, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        wr(0, 0, 1, 3'b011, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hi, mx, p, c0, pa;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cnt_a", int'(cnt_a), 0);
        check("R1 cnt_b", int'(cnt_b), 0);
        check("R1 trgo", int'(trgo), 0);
        check("R1 oc", int'(oc), 0);

        // R3 / R2 chained prescaler table
        for (int v = 0; v < NV; v++) begin
            quiet_a();
            wr(1, 1, 1, 3'b011, 3'b000, 3'b111, 0, 16'hFFFF, 0);
            wr(0, 1, 0, 3'b010, 3'b000, 3'b000, VEC[v][0], VEC[v][1], 0);
            idle(VEC[v][2] - 1);
            wr(0, 0, 0, 3'b011, 3'b000, 3'b000, VEC[v][0], VEC[v][1], 0);
            idle(4);
            p = (VEC[v][0] + 1) * (VEC[v][1] + 1);
            check("R3 b per a overflow", int'(cnt_b), VEC[v][2] / p);
            check("R2 a count", int'(cnt_a), (VEC[v][2] / (VEC[v][0] + 1)) % (VEC[v][1] + 1));
            c0 = int'(cnt_a);
            idle(5);
            check("R12 a holds when disabled", int'(cnt_a), c0);
        end

        // R7 compare output duty
        quiet_a();
        wr(0, 1, 0, 3'b011, 3'b000, 3'b000, 0, 9, 4);
        idle(3);
        hi = 0;
        for (int k = 0; k < 10; k++) begin hi += int'(oc[0]); idle(1); end
        check("R7 oc duty 4/10", hi, 4);
        wr(0, 1, 0, 3'b011, 3'b000, 3'b000, 0, 9, 0);
        hi = 0;
        for (int k = 0; k < 10; k++) begin hi += int'(oc[0]); idle(1); end
        check("R7 oc compare 0", hi, 0);
        wr(0, 1, 0, 3'b011, 3'b000, 3'b000, 0, 9, 20);
        hi = 0;
        for (int k = 0; k < 10; k++) begin hi += int'(oc[0]); idle(1); end
        check("R7 oc compare above reload", hi, 10);
        wr(0, 0, 0, 3'b011, 3'b000, 3'b000, 0, 9, 0);

        // R8 gated by A's enable (R5 master mode 001)
        quiet_a();
        wr(0, 0, 0, 3'b001, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        wr(1, 1, 1, 3'b011, 3'b000, 3'b101, 0, 16'hFFFF, 0);
        idle(5);
        check("R8 gate closed", int'(cnt_b), 0);
        wr(0, 1, 0, 3'b001, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        idle(9);
        wr(0, 0, 0, 3'b001, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        idle(3);
        check("R5 R8 gated count", int'(cnt_b), 10);
        idle(5);
        check("R8 gate reclosed", int'(cnt_b), 10);

        // R9 trigger mode start
        quiet_a();
        wr(1, 0, 1, 3'b011, 3'b000, 3'b110, 0, 16'hFFFF, 0);
        idle(3);
        check("R9 not started", int'(cnt_b), 0);
        wr(0, 1, 0, 3'b001, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        idle(9);
        check("R9 started by edge", int'(cnt_b), 7);
        wr(0, 0, 0, 3'b011, 3'b000, 3'b000, 0, 16'hFFFF, 0);

        // R10 reset mode
        quiet_a();
        wr(1, 1, 1, 3'b011, 3'b000, 3'b100, 0, 16'hFFFF, 0);
        wr(0, 1, 0, 3'b010, 3'b000, 3'b000, 0, 7, 0);
        idle(10);
        mx = 0;
        for (int k = 0; k < 40; k++) begin
            if (int'(cnt_b) > mx) mx = int'(cnt_b);
            idle(1);
        end
        check("R10 b cleared each a overflow", mx, 7);
        wr(0, 0, 0, 3'b011, 3'b000, 3'b000, 0, 7, 0);

        // R4 update request under master mode 000
        quiet_a();
        wr(0, 0, 0, 3'b000, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        wr(1, 1, 1, 3'b011, 3'b000, 3'b111, 0, 16'hFFFF, 0);
        idle(3);
        wr(0, 0, 1, 3'b000, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        idle(4);
        check("R4 one pulse per request", int'(cnt_b), 1);
        wr(0, 0, 1, 3'b000, 3'b000, 3'b000, 0, 16'hFFFF, 0);
        idle(4);
        check("R4 second request", int'(cnt_b), 2);
        check("R4 counter cleared", int'(cnt_a), 0);

        // R11 non-zero trigger select ignores A
        quiet_a();
        wr(1, 1, 1, 3'b011, 3'b001, 3'b111, 0, 16'hFFFF, 0);
        wr(0, 1, 0, 3'b010, 3'b000, 3'b000, 0, 3, 0);
        idle(20);
        check("R11 b unaffected", int'(cnt_b), 0);
        wr(0, 0, 0, 3'b011, 3'b000, 3'b000, 0, 3, 0);

        // R6 compare output as trigger
        quiet_a();
        wr(1, 1, 1, 3'b011, 3'b000, 3'b111, 0, 16'hFFFF, 0);
        wr(0, 1, 0, 3'b100, 3'b000, 3'b000, 0, 4, 2);
        idle(24);
        wr(0, 0, 0, 3'b011, 3'b000, 3'b000, 0, 4, 2);
        idle(4);
        check("R6 b per compare edge", int'(cnt_b), 5);

        // R12 disabled B in slave mode 111 ignores A's pulses
        quiet_a();
        wr(1, 0, 1, 3'b011, 3'b000, 3'b111, 0, 16'hFFFF, 0);
        wr(0, 1, 0, 3'b010, 3'b000, 3'b000, 0, 2, 0);
        idle(20);
        pa = int'(cnt_b);
        check("R12 disabled slave", pa, 0);
        wr(0, 0, 0, 3'b011, 3'b000, 3'b000, 0, 2, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule